// File: doc/BRIEF.md
# Time Base and Decrementer

This block keeps the cycle-accurate timekeeping state of a processor core: a primary 64-bit time base, an alternate 64-bit time base and a 32-bit decrementer. All three advance on a shared tick enable that comes from elsewhere in the chip. A level-sensitive run input freezes or releases the two time bases together. The decrementer does not depend on the run input.

Software reaches the counters through a small register port. A 3-bit select picks one 32-bit view, a write strobe loads that view, and a combinational read bus returns the selected view. When the decrementer counts through zero it wraps to all ones and raises a sticky exception request. A write that turns a non-negative decrementer negative raises the same request. An acknowledge pulse clears the request.

Top module: `tmbase_dec`

## Requirements
- R1: After synchronous reset, both time bases read zero, the decrementer reads 0xFFFFFFFF and the exception request is low.
- R2: While the run input is high, each tick adds one to the full 64-bit value of both time bases, with carry from the low half into the high half.
- R3: While the run input is low, ticks leave both time bases unchanged. After the run input rises again, counting resumes from the held value.
- R4: A write to a low half (select 0 for primary, 2 for alternate) replaces bits 31:0 and leaves bits 63:32 unchanged.
- R5: A write to a high half (select 1 for primary, 3 for alternate) replaces bits 63:32 and leaves bits 31:0 unchanged.
- R6: The primary and alternate time bases are independent. A write to one of them leaves the other unchanged.
- R7: A register write and a tick in the same cycle: the written counter takes the written value and does not increment in that cycle.
- R8: The decrementer (select 4) decreases by one on every tick, whatever the run input is.
- R9: A tick while the decrementer holds 0x00000000 loads 0xFFFFFFFF and sets the exception request on the next cycle.
- R10: A decrementer write with bit 31 set, made while the current value has bit 31 clear, sets the request. A write with bit 31 set made while bit 31 is already set does not.
- R11: The request stays set until an acknowledge cycle clears it. If an expiry happens in the same cycle as the acknowledge, the request stays set.
- R12: Select codes 5 to 7 read as zero, and writes to them change no state.
- R13: The read bus is combinational. A read of a time base in a cycle whose tick is active returns the value from before that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared count enable for all counters |
| tb_run | input | 1 | High lets both time bases count; low freezes them |
| reg_wr | input | 1 | Write strobe for the selected view |
| reg_sel | input | 3 | View select: 0/1 primary low/high, 2/3 alternate low/high, 4 decrementer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected view |
| irq_ack | input | 1 | Clears the decrementer exception request |
| dec_irq | output | 1 | Sticky decrementer exception request |

## Verification
The bench targets carry across the 32-bit boundary right after a low-half write near all ones. A design that dropped the carry, or that rewrote the high half on a low write, would read back the wrong high word. It freezes the time bases while the decrementer keeps ticking, and it collides a write with a tick, so a design that double-counted or ignored the run input would show an offset. For the decrementer, it drives the wrap through zero, a negative write from both signs of the current value, and an acknowledge coincident with an expiry. A design that stopped at zero, fired on every negative write, or let the acknowledge win would show the wrong request level or count.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    localparam int TMB_HALF_W = 32;
    localparam int TMB_SEL_W  = 3;
    localparam int TMB_NUM_TB = 2;

    typedef enum logic [TMB_SEL_W-1:0] {
        SEL_PRI_LO = 3'd0,
        SEL_PRI_HI = 3'd1,
        SEL_ALT_LO = 3'd2,
        SEL_ALT_HI = 3'd3,
        SEL_DEC    = 3'd4
    } tmb_sel_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } half_wr_t;

    function automatic logic [TMB_SEL_W-1:0] half_code(input int idx, input logic upper);
        return TMB_SEL_W'(2 * idx) | {{(TMB_SEL_W-1){1'b0}}, upper};
    endfunction

endpackage

// File: rtl/tmb_split_counter.sv
module tmb_split_counter
    import tmb_pkg::*;
#(
    parameter int HALF_W = TMB_HALF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  run,
    input  half_wr_t              wr,
    input  logic [HALF_W-1:0]     wr_data,
    output logic [2*HALF_W-1:0]   value
);
    localparam int FULL_W = 2 * HALF_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr.lo) begin
            value[HALF_W-1:0] <= wr_data;
        end else if (wr.hi) begin
            value[FULL_W-1:HALF_W] <= wr_data;
        end else if (tick && run) begin
            value <= value + FULL_W'(1);
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !wr.lo && !wr.hi) |=> value == $past(value) + FULL_W'(1));

    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr.lo && !wr.hi) |=> $stable(value));

    p_low_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr.lo |=> (value[HALF_W-1:0] == $past(wr_data))
                  && (value[FULL_W-1:HALF_W] == $past(value[FULL_W-1:HALF_W])));

    p_high_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr.hi && !wr.lo) |=> (value[FULL_W-1:HALF_W] == $past(wr_data))
                              && (value[HALF_W-1:0] == $past(value[HALF_W-1:0])));

endmodule

// File: rtl/tmb_decrementer.sv
module tmb_decrementer
    import tmb_pkg::*;
#(
    parameter int DEC_W = TMB_HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr,
    input  logic [DEC_W-1:0]  wr_data,
    input  logic              ack,
    output logic [DEC_W-1:0]  count,
    output logic              pend
);
    logic expire;
    logic neg_write;

    always_comb begin
        expire    = tick && !wr && (count == '0);
        neg_write = wr && wr_data[DEC_W-1] && !count[DEC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (wr) begin
            count <= wr_data;
        end else if (tick) begin
            count <= count - DEC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (expire || neg_write) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

    p_down_step_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr) |=> count == $past(count) - DEC_W'(1));

    p_wrap_raise_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr && count == '0) |=> (count == '1) && pend);

    p_neg_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr && wr_data[DEC_W-1] && !count[DEC_W-1]) |=> pend);

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);

    p_ack_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && !tick && !wr) |=> !pend);

endmodule

// File: rtl/tmbase_dec.sv
module tmbase_dec
    import tmb_pkg::*;
#(
    parameter int HALF_W = TMB_HALF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  tb_run,
    input  logic                  reg_wr,
    input  logic [TMB_SEL_W-1:0]  reg_sel,
    input  logic [HALF_W-1:0]     reg_wdata,
    output logic [HALF_W-1:0]     reg_rdata,
    input  logic                  irq_ack,
    output logic                  dec_irq
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] tb_val [TMB_NUM_TB];
    half_wr_t          tb_wr  [TMB_NUM_TB];
    logic [HALF_W-1:0] dec_val;
    logic              dec_wr;

    genvar gi;
    generate
        for (gi = 0; gi < TMB_NUM_TB; gi++) begin : g_tb
            always_comb begin
                tb_wr[gi].lo = reg_wr && (reg_sel == half_code(gi, 1'b0));
                tb_wr[gi].hi = reg_wr && (reg_sel == half_code(gi, 1'b1));
            end

            tmb_split_counter #(.HALF_W(HALF_W)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick_en),
                .run     (tb_run),
                .wr      (tb_wr[gi]),
                .wr_data (reg_wdata),
                .value   (tb_val[gi])
            );
        end
    endgenerate

    assign dec_wr = reg_wr && (reg_sel == SEL_DEC);

    tmb_decrementer #(.DEC_W(HALF_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .wr      (dec_wr),
        .wr_data (reg_wdata),
        .ack     (irq_ack),
        .count   (dec_val),
        .pend    (dec_irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < TMB_NUM_TB; i++) begin
            if (reg_sel == half_code(i, 1'b0)) reg_rdata = tb_val[i][HALF_W-1:0];
            if (reg_sel == half_code(i, 1'b1)) reg_rdata = tb_val[i][FULL_W-1:HALF_W];
        end
        if (reg_sel == SEL_DEC) reg_rdata = dec_val;
    end

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (reg_sel > SEL_DEC) |-> reg_rdata == '0);

endmodule

// File: tb/tb_tmbase_dec.sv
module tb_tmbase_dec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        tb_run = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        irq_ack = 1'b0;
    logic [31:0] reg_rdata;
    logic        dec_irq;

    always #4 clk = ~clk;

    tmbase_dec dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .tb_run(tb_run),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ack(irq_ack), .dec_irq(dec_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // expectation model built from the requirements
    logic [63:0] m_tb [2];
    logic [31:0] m_dec;
    logic        m_irq;

    initial begin
        forever begin
            item_t       it;
            logic [31:0] act;
            @(chk_ev);
            while (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, dec_irq} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    function automatic logic [31:0] model_view(input logic [2:0] sel);
        case (sel)
            3'd0: return m_tb[0][31:0];
            3'd1: return m_tb[0][63:32];
            3'd2: return m_tb[1][31:0];
            3'd3: return m_tb[1][63:32];
            3'd4: return m_dec;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_update(input logic tk, input logic wr, input logic [2:0] sel,
                                input logic [31:0] d, input logic ack);
        logic set;
        set = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (wr && sel == 3'(2*i))        m_tb[i] = {m_tb[i][63:32], d};
            else if (wr && sel == 3'(2*i+1)) m_tb[i] = {d, m_tb[i][31:0]};
            else if (tk && tb_run)           m_tb[i] = m_tb[i] + 64'd1;
        end
        if (wr && sel == 3'd4) begin
            if (d[31] && !m_dec[31]) set = 1'b1;
            m_dec = d;
        end else if (tk) begin
            if (m_dec == 32'd0) set = 1'b1;
            m_dec = m_dec - 32'd1;
        end
        if (set) m_irq = 1'b1;
        else if (ack) m_irq = 1'b0;
    endtask

    // one clock cycle of stimulus; called just after a falling edge
    task automatic step(input logic tk, input logic wr, input logic [2:0] sel,
                        input logic [31:0] d, input logic ack);
        tick_en = tk; reg_wr = wr; reg_sel = sel; reg_wdata = d; irq_ack = ack;
        model_update(tk, wr, sel, d, ack);
        @(negedge clk);
        tick_en = 1'b0; reg_wr = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 32'd0, 1'b0);
    endtask

    task automatic push(input bit is_irq, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_irq = is_irq; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        ->chk_ev;
    endtask

    // read a view with a literal expectation, consuming one idle cycle
    task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        if (exp !== model_view(sel)) $display("note: model and literal differ for %s", tag);
        push(1'b0, exp, tag);
        @(negedge clk);
    endtask

    task automatic rdm(input logic [2:0] sel, input string tag);
        reg_sel = sel;
        #1;
        push(1'b0, model_view(sel), tag);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        push(1'b1, {31'd0, exp}, tag);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_tb[0] = 64'd0; m_tb[1] = 64'd0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(3'd0, 32'h0, "R1 primary low");
        rd(3'd1, 32'h0, "R1 primary high");
        rd(3'd2, 32'h0, "R1 alt low");
        rd(3'd3, 32'h0, "R1 alt high");
        rd(3'd4, 32'hFFFF_FFFF, "R1 decrementer");
        chk_irq(1'b0, "R1 request low");

        // R2 counting, R8 decrementer follows tick
        tb_run = 1'b1;
        ticks(5);
        rd(3'd0, 32'd5, "R2 primary low after 5 ticks");
        rd(3'd2, 32'd5, "R2 alt low after 5 ticks");
        rd(3'd4, 32'hFFFF_FFFA, "R8 decrementer after 5 ticks");

        // R3 freeze, R8 independent of run
        tb_run = 1'b0;
        ticks(4);
        rd(3'd0, 32'd5, "R3 primary held");
        rd(3'd2, 32'd5, "R3 alt held");
        rd(3'd4, 32'hFFFF_FFF6, "R8 decrementer ticks while frozen");
        tb_run = 1'b1;
        ticks(2);
        rd(3'd0, 32'd7, "R3 resume without jump");

        // R4 low write, R6 independence
        step(1'b0, 1'b1, 3'd0, 32'hFFFF_FFFE, 1'b0);
        rd(3'd0, 32'hFFFF_FFFE, "R4 low half written");
        rd(3'd1, 32'h0, "R4 high half kept");
        rd(3'd2, 32'd7, "R6 alt untouched by primary write");
        ticks(3);
        rd(3'd0, 32'd1, "R2 low wraps");
        rd(3'd1, 32'd1, "R2 carry into high half");
        rd(3'd2, 32'hA, "R2 alt keeps counting");

        // R5 high write
        step(1'b0, 1'b1, 3'd1, 32'h1234_5678, 1'b0);
        rd(3'd1, 32'h1234_5678, "R5 high half written");
        rd(3'd0, 32'd1, "R5 low half kept");
        rd(3'd3, 32'h0, "R6 alt high untouched");

        // R7 write collides with tick
        step(1'b1, 1'b1, 3'd2, 32'h100, 1'b0);
        rd(3'd2, 32'h100, "R7 written value wins over tick");
        rd(3'd0, 32'd2, "R7 other counter still ticks");

        // R13 read during tick returns pre-tick value
        reg_sel = 3'd0;
        tick_en = 1'b1;
        #1;
        push(1'b0, 32'd2, "R13 read in tick cycle");
        model_update(1'b1, 1'b0, 3'd0, 32'd0, 1'b0);
        @(negedge clk);
        tick_en = 1'b0;
        rd(3'd0, 32'd3, "R13 value after the tick");

        // R9 expiry
        step(1'b0, 1'b1, 3'd4, 32'd2, 1'b0);
        chk_irq(1'b0, "R9 positive write no request");
        ticks(2);
        rd(3'd4, 32'd0, "R9 reached zero");
        chk_irq(1'b0, "R9 no request at zero");
        ticks(1);
        rd(3'd4, 32'hFFFF_FFFF, "R9 wrap to all ones");
        chk_irq(1'b1, "R9 request on expiry");

        // R11 sticky and ack
        step(1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
        step(1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
        chk_irq(1'b1, "R11 request sticky");
        step(1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
        chk_irq(1'b0, "R11 ack clears");
        step(1'b0, 1'b1, 3'd4, 32'd0, 1'b0);
        step(1'b1, 1'b0, 3'd0, 32'd0, 1'b1);
        chk_irq(1'b1, "R11 expiry wins over ack");
        rd(3'd4, 32'hFFFF_FFFF, "R11 wrapped during ack");

        // R10 negative writes
        step(1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
        step(1'b0, 1'b1, 3'd4, 32'd5, 1'b0);
        chk_irq(1'b0, "R10 cleared before test");
        step(1'b0, 1'b1, 3'd4, 32'h8000_0000, 1'b0);
        chk_irq(1'b1, "R10 positive to negative write");
        rd(3'd4, 32'h8000_0000, "R10 value loaded");
        step(1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
        step(1'b0, 1'b1, 3'd4, 32'h9000_0000, 1'b0);
        chk_irq(1'b0, "R10 negative to negative write");
        rd(3'd4, 32'h9000_0000, "R10 second value loaded");

        // R12 unmapped selects
        step(1'b0, 1'b1, 3'd5, 32'hDEAD_BEEF, 1'b0);
        step(1'b0, 1'b1, 3'd7, 32'hCAFE_F00D, 1'b0);
        rd(3'd5, 32'h0, "R12 select 5 reads zero");
        rd(3'd7, 32'h0, "R12 select 7 reads zero");
        rd(3'd4, 32'h9000_0000, "R12 decrementer unchanged");
        rd(3'd1, 32'h1234_5678, "R12 primary high unchanged");
        rdm(3'd0, "R12 primary low unchanged");
        rdm(3'd2, "R12 alt low unchanged");
        chk_irq(1'b0, "R12 request unchanged");

        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule